// File: doc/BRIEF.md
# SHA-256 Message Schedule Unit

This unit supplies the per-round schedule word Wt to a SHA-256 compression core that retires one round per clock. During the first sixteen steps of a block, the padding logic feeds 32-bit message words to it. Each word appears on `wt` in the same step and is also shifted into a sixteen-word history window. For the remaining forty-eight steps the unit runs on its own. It derives each new word from four taps of the window with the two small-sigma mixing functions, puts that word on `wt`, and shifts it back into the window.

An external sequencer drives two controls. `ld` chooses between pass-through and self-generation. `ce` advances the window by one step. When `ce` is low the whole window freezes, so an input wait state or the one-cycle pause between blocks never lets `wt` slip against the round constant that the sequencer addresses with the same step index. A synchronous reset clears the window.

Top module: `msg_schedule`

## Requirements
- R1: While `ld` is 1, `wt` equals `din` in the same cycle, whatever `ce` is.
- R2: On a rising edge with `ce`=1 and `ld`=1, `din` enters the newest window slot and every older entry moves one slot back. After 16 such loads, the window holds exactly those 16 words.
- R3: While `ld` is 0, `wt` = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^32, where W[t-k] is the word shifted in k steps ago. s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x) and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R4: On a rising edge with `ce`=1 and `ld`=0, the generated `wt` enters the window, so a full block of 16 loads followed by 48 recirculating steps yields the standard 64-word expansion.
- R5: On an edge with `ce`=0 the window does not change. Neither `din` nor `ld` has any effect on later words, and with `ld`=0 `wt` keeps its value.
- R6: A synchronous `rst` empties the window to all-zero words, so with `ld`=0 right after reset `wt` reads 0.
- R7: The window keeps its contents across an idle cycle (`ce`=0) between blocks. During that cycle, with `ld`=0, `wt` shows the word that follows the last word of the previous block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of the window |
| ce | input | 1 | Step enable; low freezes the window |
| ld | input | 1 | 1: pass `din` through and store it; 0: self-generate |
| din | input | 32 | Message word from the padding logic |
| wt | output | 32 | Schedule word for the current round |

## Verification
The bench goes after alignment. It inserts random wait cycles with garbage on `din` and a random `ld` inside both the load and the recirculate phases. A design that shifted while `ce` is low would take in garbage words or skip a step, and every later Wt of the block would be wrong. A known padded block checks W16 and W17 exactly; a design that swapped the two sigma functions or mis-tapped the window fails there first. The bench also checks the reset value of `wt` and the word shown during the idle cycle between blocks, which catch a window that does not clear or that loses its contents between blocks.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t small_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sched_window.sv
module sched_window #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ce,
  input  logic [WORD_W-1:0]             shift_in,
  output logic [DEPTH-1:0][WORD_W-1:0]  win
);
  localparam int NEWEST = DEPTH - 1;

  // slot NEWEST holds W[t-1], slot 0 holds W[t-DEPTH]
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == NEWEST) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)     win[i] <= '0;
          else if (ce) win[i] <= shift_in;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)     win[i] <= '0;
          else if (ce) win[i] <= win[i+1];
        end
      end
    end
  endgenerate

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    ce |=> win[NEWEST-1] == $past(win[NEWEST]));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(win));

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;
  always @(posedge clk) begin
    if (rst_seen) assert_clear_R6: assert (win == '0);
  end
endmodule

// File: rtl/sched_expand.sv
module sched_expand
  import sched_pkg::*;
(
  input  word_t tap2,
  input  word_t tap7,
  input  word_t tap15,
  input  word_t tap16,
  output word_t next_w
);
  word_t mix_hi;
  word_t mix_lo;

  always_comb begin
    mix_hi = small_s1(tap2) + tap7;
    mix_lo = small_s0(tap15) + tap16;
    next_w = mix_hi + mix_lo;
  end
endmodule

// File: rtl/msg_schedule.sv
module msg_schedule
  import sched_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              ld,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] wt
);
  localparam int NEWEST = DEPTH - 1;
  localparam int IDX_T2  = DEPTH - 2;
  localparam int IDX_T7  = DEPTH - 7;
  localparam int IDX_T15 = DEPTH - 15;
  localparam int IDX_T16 = DEPTH - 16;

  logic [DEPTH-1:0][WORD_W-1:0] win;
  word_t gen_w;

  sched_expand u_expand (
    .tap2   (win[IDX_T2]),
    .tap7   (win[IDX_T7]),
    .tap15  (win[IDX_T15]),
    .tap16  (win[IDX_T16]),
    .next_w (gen_w)
  );

  always_comb wt = ld ? din : gen_w;

  sched_window #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_window (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .shift_in (wt),
    .win      (win)
  );

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && ld) |=> win[NEWEST] == $past(din));

  assert_recirc_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && !ld) |=> win[NEWEST] == $past(gen_w));

  assert_wt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ce && !ld) |=> (ld || $stable(wt)));
endmodule

// File: tb/test_msg_schedule.sv
module test_msg_schedule;
  logic        clk = 1'b0;
  logic        rst, ce, ld;
  logic [31:0] din;
  logic [31:0] wt;
  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  msg_schedule i_msg_schedule (
    .clk(clk), .rst(rst), .ce(ce), .ld(ld), .din(din), .wt(wt)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] s0(input logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
  endfunction
  function automatic logic [31:0] s1(input logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
  endfunction

  logic [31:0] w [0:64];

  task automatic check(input string req, input logic [31:0] exp);
    n_vec++;
    if (wt !== exp) begin
      n_bad++;
      $display("FAIL %s: wt=%08h expected %08h", req, wt, exp);
    end
  endtask

  // drive at negedge, sample 1 ns later, capture at the next posedge
  task automatic drive(input logic c, input logic l, input logic [31:0] d);
    @(negedge clk);
    ce = c; ld = l; din = d;
    #1;
  endtask

  task automatic run_block(input bit directed, input int wait_pct);
    for (int t = 0; t < 16; t++)
      w[t] = directed ? (t == 0 ? 32'h61626380 : (t == 15 ? 32'h18 : 32'h0)) : $urandom;
    for (int t = 16; t < 65; t++)
      w[t] = s1(w[t-2]) + w[t-7] + s0(w[t-15]) + w[t-16];
    for (int t = 0; t < 64; t++) begin
      while (($urandom % 100) < wait_pct) begin
        if (t < 16) begin
          logic [31:0] junk = $urandom;
          drive(1'b0, 1'b1, junk);
          check("R1 pass-through during wait", junk);
        end else begin
          drive(1'b0, 1'b0, $urandom);
          check("R5 wt held during wait", w[t]);
        end
      end
      drive(1'b1, t < 16, w[t]);
      if (t < 16) check("R1 pass-through", w[t]);
      else        check("R3 R4 generated word", w[t]);
    end
    // idle cycle between blocks
    drive(1'b0, 1'b0, $urandom);
    check("R7 window kept across pause", w[64]);
  endtask

  initial begin
    rst = 1'b1; ce = 1'b0; ld = 1'b0; din = '0;
    void'($urandom(32'h5A5A1234));
    repeat (3) @(posedge clk);
    drive(1'b1, 1'b0, 32'hFFFF_FFFF);
    rst = 1'b0;
    #1;
    check("R6 cleared window", 32'h0);
    drive(1'b1, 1'b0, 32'hDEAD_BEEF);
    check("R6 zero window keeps generating zero", 32'h0);
    drive(1'b0, 1'b0, 32'h1234_5678);

    // directed padded block: W16 and W17 are known
    run_block(1'b1, 0);
    if (w[16] !== 32'h61626380 || w[17] !== 32'h000F0000) begin
      n_bad++;
      $display("FAIL R3: bench vector W16=%08h W17=%08h expected 61626380 000f0000", w[16], w[17]);
    end
    run_block(1'b1, 30);
    for (int b = 0; b < 12; b++) run_block(1'b0, (b % 3) * 20);

    // reset mid-stream clears the window again
    @(negedge clk); rst = 1'b1; ce = 1'b1; ld = 1'b0;
    @(negedge clk); rst = 1'b0; ce = 1'b0; #1;
    check("R6 clear after activity", 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule